// File: doc/BRIEF.md
# Endpoint Control Register with Buffer Toggle

This block is the control and status register of one bulk endpoint in a USB device controller. Firmware uses it to pick which of two 512-byte SRAM buffers is streamed out next. A pick is accepted only when a qualifier bit is set in the same write. An accepted pick emits a one-cycle pulse that clears the read-done interrupt flag of the buffer just chosen.

The register also holds a single stall flag that covers both directions of the endpoint. Either firmware or the serial interface engine (SIE) can raise it. Only host-side events can drop it: a clear of the endpoint halt for either direction, a set-configuration command, or a bus reset.

Reads return the current buffer choice, the stall flag, and the SIE's enable status. All other bits read as zero. Every pin is a plain control or status signal, so there is no streaming handshake at the edge.

Top module: `ep_ctl_reg`

## Requirements
- R1: After reset, `buf_sel` and `stall` are 0, no clear pulse is active, and `rd_data` equals the enable bit at position 1 with all other bits 0.
- R2: A write with bit 0 set loads `buf_sel` from write bit 4 (0 = buffer A, 1 = buffer B). The new value appears on `buf_sel` and on `rd_data` bit 4 in the cycle after the write.
- R3: A write with bit 0 clear leaves `buf_sel` unchanged, whatever bit 4 holds.
- R4: In the cycle after an accepted select write, exactly one clear pulse is high for one cycle: `clr_done_b` if bit 4 was 1, `clr_done_a` if bit 4 was 0. No pulse follows any other cycle.
- R5: `stall` is set in the cycle after a write with bit 2 set or after `sie_stall_set` is high. It reads back on `rd_data` bit 2.
- R6: A firmware write with bit 2 clear does not clear a set stall.
- R7: `stall` is cleared in the cycle after any one of `clr_halt_rx`, `clr_halt_tx`, `set_config` or `bus_reset` is high, when no set request is present in that cycle.
- R8: When a set request and a clear event occur in the same cycle, `stall` is 1 afterwards.
- R9: `rd_data` bit 1 follows `sie_ep_enabled` combinationally. Bits 0, 3 and 7..5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data (bit 4 select, bit 2 stall, bit 0 qualifier) |
| rd_data | output | 8 | Read data |
| sie_stall_set | input | 1 | SIE request to set stall |
| sie_ep_enabled | input | 1 | SIE reports endpoint enabled in some direction |
| clr_halt_rx | input | 1 | Host cleared the halt for the receive direction |
| clr_halt_tx | input | 1 | Host cleared the halt for the transmit direction |
| set_config | input | 1 | Host set-configuration command seen |
| bus_reset | input | 1 | USB bus reset seen |
| buf_sel | output | 1 | Buffer to output next (0 = A, 1 = B) |
| stall | output | 1 | Endpoint stall condition, both directions |
| clr_done_a | output | 1 | One-cycle clear of the buffer A read-done flag |
| clr_done_b | output | 1 | One-cycle clear of the buffer B read-done flag |

## Verification
The assertions assume that the host events, the SIE request and the write strobe are synchronous single-cycle levels sampled at the clock edge. They place no limit on how these inputs combine. The stimulus drives them at the falling edge. It deliberately raises set and clear in the same cycle, and it sends many writes with bit 4 set but the qualifier clear. Clear events are kept rare in the random mix, so the stall flag spends long stretches set and the firmware-zero write case gets exercised.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;
  localparam int unsigned QUAL_BIT  = 0;
  localparam int unsigned EN_BIT    = 1;
  localparam int unsigned STALL_BIT = 2;
  localparam int unsigned SEL_BIT   = 4;
  localparam int unsigned N_CLR     = 4;
endpackage

// File: rtl/ep_bufsel.sv
module ep_bufsel (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_qual,
  input  logic wr_sel,
  output logic buf_sel,
  output logic clr_a,
  output logic clr_b
);
  logic accept;
  assign accept = wr_en & wr_qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_sel <= 1'b0;
      clr_a   <= 1'b0;
      clr_b   <= 1'b0;
    end else begin
      clr_a <= accept & ~wr_sel;
      clr_b <= accept &  wr_sel;
      if (accept) buf_sel <= wr_sel;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_qual) |=> $stable(buf_sel)); // R3
  AST_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_a, clr_b})); // R4
  AST_NO_STRAY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_qual) |=> !(clr_a || clr_b)); // R4
  AST_CLR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a || clr_b) |-> (clr_b == buf_sel)); // R2
endmodule

// File: rtl/ep_stall.sv
module ep_stall #(
  parameter int unsigned N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic [N_EVT-1:0] clr_evt,
  output logic             stall
);
  logic any_clr;
  assign any_clr = |clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stall <= 1'b0;
    else if (set_req) stall <= 1'b1;
    else if (any_clr) stall <= 1'b0;
  end

  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !any_clr) |=> stall); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> stall); // R8
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (any_clr && !set_req) |=> !stall); // R7
endmodule

// File: rtl/ep_ctl_reg.sv
module ep_ctl_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sie_stall_set,
  input  logic              sie_ep_enabled,
  input  logic              clr_halt_rx,
  input  logic              clr_halt_tx,
  input  logic              set_config,
  input  logic              bus_reset,
  output logic              buf_sel,
  output logic              stall,
  output logic              clr_done_a,
  output logic              clr_done_b
);
  import ep_ctl_pkg::*;

  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << QUAL_BIT) | (1 << STALL_BIT) | (1 << SEL_BIT));

  logic             unused_wr;
  logic [N_CLR-1:0] clr_vec;
  logic             fw_stall_set;

  assign unused_wr    = ^(wr_data & ~USED_MASK);
  assign clr_vec      = {bus_reset, set_config, clr_halt_tx, clr_halt_rx};
  assign fw_stall_set = wr_en & wr_data[STALL_BIT];

  ep_bufsel u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_qual (wr_data[QUAL_BIT]),
    .wr_sel  (wr_data[SEL_BIT]),
    .buf_sel (buf_sel),
    .clr_a   (clr_done_a),
    .clr_b   (clr_done_b)
  );

  ep_stall #(.N_EVT(N_CLR)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (fw_stall_set | sie_stall_set),
    .clr_evt (clr_vec),
    .stall   (stall)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[EN_BIT]    = sie_ep_enabled;
    rd_data[STALL_BIT] = stall;
    rd_data[SEL_BIT]   = buf_sel;
  end

  AST_RD_QUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[QUAL_BIT]) |=> !rd_data[QUAL_BIT]); // R9
  AST_FW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[STALL_BIT]) |=> rd_data[STALL_BIT]); // R5
endmodule

// File: tb/ep_ctl_reg_bench.sv
module ep_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sie_stall_set = 1'b0, sie_ep_enabled = 1'b0;
  logic       clr_halt_rx = 1'b0, clr_halt_tx = 1'b0, set_config = 1'b0, bus_reset = 1'b0;
  logic       buf_sel, stall, clr_done_a, clr_done_b;

  int n_tests = 0;
  int n_fail  = 0;
  logic e_sel = 1'b0, e_stall = 1'b0, e_ca = 1'b0, e_cb = 1'b0;

  always #2 clk = ~clk;

  ep_ctl_reg u_ep_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sie_stall_set(sie_stall_set), .sie_ep_enabled(sie_ep_enabled),
    .clr_halt_rx(clr_halt_rx), .clr_halt_tx(clr_halt_tx),
    .set_config(set_config), .bus_reset(bus_reset),
    .buf_sel(buf_sel), .stall(stall), .clr_done_a(clr_done_a), .clr_done_b(clr_done_b)
  );

  function automatic logic [7:0] exp_rd(input logic s, input logic st, input logic en);
    return {3'b000, s, 1'b0, st, en, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d, input logic sie,
                      input logic en, input logic [3:0] clr, input string tag);
    logic set;
    @(negedge clk);
    wr_en = we; wr_data = d; sie_stall_set = sie; sie_ep_enabled = en;
    {bus_reset, set_config, clr_halt_tx, clr_halt_rx} = clr;
    e_ca = 1'b0; e_cb = 1'b0;
    if (we && d[0]) begin e_sel = d[4]; e_ca = ~d[4]; e_cb = d[4]; end
    set = (we && d[2]) || sie;
    if (set) e_stall = 1'b1;
    else if (|clr) e_stall = 1'b0;
    @(posedge clk); #1;
    chk({tag, " R2/R3 buf_sel"}, {7'd0, buf_sel}, {7'd0, e_sel});
    chk({tag, " R5/R7/R8 stall"}, {7'd0, stall}, {7'd0, e_stall});
    chk({tag, " R4 clear pulses"}, {6'd0, clr_done_b, clr_done_a}, {6'd0, e_cb, e_ca});
    chk({tag, " R9 rd_data"}, rd_data, exp_rd(e_sel, e_stall, en));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    sie_ep_enabled = 1'b1;
    #1;
    chk("R1 reset rd_data", rd_data, exp_rd(1'b0, 1'b0, 1'b1));
    chk("R1 reset outputs", {4'd0, buf_sel, stall, clr_done_a, clr_done_b}, 8'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R2: accepted select of B, then A
    step(1'b1, 8'h11, 1'b0, 1'b1, 4'h0, "R2 sel B");
    step(1'b0, 8'h00, 1'b0, 1'b1, 4'h0, "R4 pulse ends");
    step(1'b1, 8'h01, 1'b0, 1'b0, 4'h0, "R2 sel A");
    // R3: bit 4 without qualifier ignored
    step(1'b1, 8'hF0, 1'b0, 1'b0, 4'h0, "R3 no qual");
    // R5 firmware set, R6 write zero does not clear
    step(1'b1, 8'h04, 1'b0, 1'b1, 4'h0, "R5 fw set");
    step(1'b1, 8'h00, 1'b0, 1'b1, 4'h0, "R6 fw zero");
    // R7 each clear source
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 8'h00, 1'b1, 1'b1, 4'h0, "R5 sie set");
      step(1'b0, 8'h00, 1'b0, 1'b1, 4'(1 << i), "R7 clear");
    end
    // R8 set wins
    step(1'b0, 8'h00, 1'b1, 1'b0, 4'hF, "R8 sie vs clr");
    step(1'b1, 8'h04, 1'b0, 1'b0, 4'h2, "R8 fw vs clr");
    // R9 reserved bits with all-ones write
    step(1'b1, 8'hFF, 1'b0, 1'b1, 4'h0, "R9 all ones");
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] c;
      c = 4'(($urandom % 8 == 0) ? (1 << ($urandom % 4)) : 0);
      step(($urandom % 2) == 0, 8'($urandom), ($urandom % 10) == 0,
           ($urandom % 2) == 0, c, "rand");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule